// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the master half of an I2C controller. It executes one byte-level step per software command. A command word holds one bit for each step: START, transmit a byte, receive a byte, a receive-last qualifier, and STOP. When several bits are set together, the engine runs them in a fixed order: START first, then the transmit or receive byte, then STOP. A single write can therefore produce a START, the address byte and a STOP.

Bytes pass through a 16-bit buffer. Transmit data is written into the low byte. Each completed receive places its byte in the high byte. The result of every step is reported through sticky status bits that software clears by writing 1. An enable mask selects which of those bits drive the single interrupt line.

Bus timing comes from a tick input supplied by an external SCL generator. Each bus operation (START, STOP or one data bit) takes four ticks. While SCL is released high, the engine waits for the line to actually rise, which honours clock stretching. A hold-low that outlasts a cycle limit aborts the step.

Top module: `i2c_mbe`

## Requirements
- R1: After reset the status bits, the interrupt and the bus-busy flag are 0. The engine reports idle, and both bus lines are released high.
- R2: Command bit 0 (START) generates a START condition and sets bus-busy. Command bit 1 (transmit) shifts out buffer bits 7:0 MSB first, then samples the ninth bit. A low ninth bit sets status bit 0 (ACK) and a high ninth bit sets status bit 1 (NACK).
- R3: Command bit 3 (receive) clocks in 8 bits MSB first, places them in buffer bits 15:8 and sets status bit 2. On the ninth bit the engine drives ACK (low), or NACK (high) when command bit 4 (receive-last) is also set.
- R4: Command bit 5 (STOP) generates a STOP condition, clears bus-busy, leaves both lines high and sets status bit 4.
- R5: Bits set together in one command run in the order START, transmit or receive, STOP.
- R6: If the engine releases SDA on a transmitted bit but samples it low, it sets status bit 3 (arbitration lost). It also discards every queued command bit (a queued STOP does not run), clears bus-busy and releases both lines.
- R7: If SCL stays low for TIMEOUT_CYC cycles after being released, the engine sets status bit 6, discards the queued bits, clears bus-busy and releases both lines.
- R8: Status bit 5 (abnormal) is set and the bus is left untouched for any of these commands: transmit and receive together; transmit, receive or STOP without START while the bus is not owned; receive-last without receive.
- R9: A command write or a buffer write that arrives while a command is still executing has no effect.
- R10: Writing 1 to a status bit clears it. Bits written with 0 keep their value.
- R11: The interrupt output is high exactly when some status bit is set whose enable bit, at the same bit position, is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe from the SCL generator |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 6 | Command bits (0 START, 1 TX, 3 RX, 4 RX-last, 5 STOP) |
| buf_wr | input | 1 | Transmit byte write strobe |
| buf_wdata | input | 8 | Transmit byte |
| buf_rdata | output | 16 | {received byte, transmit byte} |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_data | input | 7 | Write-1-to-clear mask |
| en_wr | input | 1 | Interrupt enable write strobe |
| en_wdata | input | 7 | Interrupt enable mask |
| sts_o | output | 7 | Status bits |
| irq | output | 1 | Interrupt request |
| bus_busy | output | 1 | Bus owned between START and STOP |
| engine_idle | output | 1 | No command queued or executing |
| scl_o | output | 1 | SCL drive (0 pulls low) |
| sda_o | output | 1 | SDA drive (0 pulls low) |
| scl_i | input | 1 | Sensed SCL |
| sda_i | input | 1 | Sensed SDA |

## Verification
The bench sweeps transmit and receive bytes across all-zero, all-one, alternating and single-bit patterns. An engine that shifts LSB first, or drops a bit, returns a wrong byte. The ninth bit is checked in both directions: a swapped ACK/NACK polarity, or a receive-last that fails to NACK, shows up as a wrong line level or status bit. Arbitration loss is provoked with a queued STOP behind it, to catch an engine that flushes the queue too late and still sends STOP. A held-low SCL checks that the stretch wait ends in a timeout rather than a hang. Malformed commands, and writes arriving mid-byte, must leave the bus and the queue untouched.

// File: rtl/i2c_mbe_pkg.sv
package i2c_mbe_pkg;
    localparam int CMD_W  = 6;
    localparam int STS_W  = 7;
    localparam int BYTE_W = 8;

    // command bit positions
    localparam int C_STA  = 0;
    localparam int C_TX   = 1;
    localparam int C_RX   = 3;
    localparam int C_LAST = 4;
    localparam int C_STO  = 5;
    localparam logic [CMD_W-1:0] CMD_MASK = 6'b111011;

    // status bit positions
    localparam int S_ACK = 0;
    localparam int S_NAK = 1;
    localparam int S_RXD = 2;
    localparam int S_ARB = 3;
    localparam int S_STP = 4;
    localparam int S_ABN = 5;
    localparam int S_TMO = 6;

    typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} bus_op_e;
    typedef enum logic [1:0] {STG_START, STG_TX, STG_RX, STG_STOP} stage_e;
endpackage

// File: rtl/i2c_mbe_bitphy.sv
module i2c_mbe_bitphy
    import i2c_mbe_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    op_valid,
    input  bus_op_e op_in,
    input  logic    wbit_in,
    input  logic    chk_in,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    done,
    output logic    rbit,
    output logic    arb,
    output logic    tmo,
    output logic    scl_o,
    output logic    sda_o
);
    localparam int TCW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic           busy;
        bus_op_e        op;
        logic [1:0]     ph;
        logic           wbit;
        logic           chk;
        logic           arb;
        logic           tmo;
        logic           done;
        logic           rbit;
        logic           scl;
        logic           sda;
        logic [TCW-1:0] tcnt;
    } phy_t;

    phy_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (op_valid) begin
                d.busy = 1'b1;
                d.op   = op_in;
                d.ph   = 2'd0;
                d.wbit = wbit_in;
                d.chk  = chk_in;
                d.arb  = 1'b0;
                d.tmo  = 1'b0;
                d.tcnt = '0;
            end
        end else if (q.ph == 2'd2 && !scl_i) begin
            // SCL released but still held low by the bus
            if (q.tcnt == TCW'(TIMEOUT_CYC - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.tmo  = 1'b1;
                d.scl  = 1'b1;
                d.sda  = 1'b1;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            case (q.ph)
                2'd0: begin
                    case (q.op)
                        OP_START: d.sda = 1'b1;
                        OP_STOP:  begin d.scl = 1'b0; d.sda = 1'b0; end
                        default:  begin d.scl = 1'b0; d.sda = q.wbit; end
                    endcase
                end
                2'd1: begin
                    d.scl = 1'b1;
                    case (q.op)
                        OP_START: d.sda = 1'b1;
                        OP_STOP:  d.sda = 1'b0;
                        default:  d.sda = q.wbit;
                    endcase
                end
                2'd2: begin
                    case (q.op)
                        OP_START: d.sda = 1'b0;
                        OP_STOP:  d.sda = 1'b1;
                        default: begin
                            d.rbit = sda_i;
                            if (q.chk && q.wbit && !sda_i) d.arb = 1'b1;
                        end
                    endcase
                end
                default: begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    if (q.arb) begin
                        d.scl = 1'b1;
                        d.sda = 1'b1;
                    end else if (q.op != OP_STOP) begin
                        d.scl = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.op  <= OP_START;
            q.scl <= 1'b1;
            q.sda <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done  = q.done;
    assign rbit  = q.rbit;
    assign arb   = q.arb;
    assign tmo   = q.tmo;
    assign scl_o = q.scl;
    assign sda_o = q.sda;
endmodule

// File: rtl/i2c_mbe_status.sv
module i2c_mbe_status
    import i2c_mbe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    input  logic             en_wr,
    input  logic [STS_W-1:0] en_wdata,
    output logic [STS_W-1:0] sts,
    output logic             irq
);
    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic [STS_W-1:0] en;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        // a new event wins over a simultaneous clear
        d.sts = (q.sts & ~(clr_wr ? clr_data : '0)) | set;
        if (en_wr) d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sts = q.sts;
    assign irq = |(q.sts & q.en);
endmodule

// File: rtl/i2c_mbe.sv
module i2c_mbe
    import i2c_mbe_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              buf_wr,
    input  logic [BYTE_W-1:0] buf_wdata,
    output logic [2*BYTE_W-1:0] buf_rdata,
    input  logic              sts_clr_wr,
    input  logic [STS_W-1:0]  sts_clr_data,
    input  logic              en_wr,
    input  logic [STS_W-1:0]  en_wdata,
    output logic [STS_W-1:0]  sts_o,
    output logic              irq,
    output logic              bus_busy,
    output logic              engine_idle,
    output logic              scl_o,
    output logic              sda_o,
    input  logic              scl_i,
    input  logic              sda_i
);
    localparam int IDXW = $clog2(BYTE_W + 1);
    localparam logic [IDXW-1:0] LAST_DATA = IDXW'(BYTE_W - 1);
    localparam logic [IDXW-1:0] ACK_SLOT  = IDXW'(BYTE_W);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic              owned;
        logic              run;
        stage_e            stg;
        logic [IDXW-1:0]   idx;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              opv;
        bus_op_e           op;
        logic              wbit;
        logic              chk;
    } seq_t;

    seq_t q, d;
    logic [STS_W-1:0] sts_set;
    logic             phy_done, phy_rbit, phy_arb, phy_tmo;
    logic             idle_now, owns, bad;
    logic [CMD_W-1:0] cmd_w;

    assign idle_now = (q.cmd == '0) && !q.run;
    assign cmd_w    = cmd_wdata & CMD_MASK;
    assign owns     = q.owned | cmd_w[C_STA];
    assign bad      = (cmd_w[C_TX] & cmd_w[C_RX])
                    | ((cmd_w[C_TX] | cmd_w[C_RX] | cmd_w[C_STO]) & ~owns)
                    | (cmd_w[C_LAST] & ~cmd_w[C_RX]);

    always_comb begin
        d       = q;
        d.opv   = 1'b0;
        sts_set = '0;

        if (buf_wr && idle_now) d.tx = buf_wdata;

        if (cmd_wr && idle_now && cmd_w != '0) begin
            if (bad) sts_set[S_ABN] = 1'b1;
            else     d.cmd = cmd_w;
        end

        // launch the next pending step in fixed order
        if (!q.run && q.cmd != '0) begin
            d.run  = 1'b1;
            d.opv  = 1'b1;
            d.idx  = '0;
            d.chk  = 1'b0;
            d.wbit = 1'b1;
            if (q.cmd[C_STA]) begin
                d.stg = STG_START;
                d.op  = OP_START;
            end else if (q.cmd[C_TX]) begin
                d.stg  = STG_TX;
                d.op   = OP_BIT;
                d.sh   = q.tx;
                d.wbit = q.tx[BYTE_W-1];
                d.chk  = 1'b1;
            end else if (q.cmd[C_RX]) begin
                d.stg = STG_RX;
                d.op  = OP_BIT;
            end else begin
                d.stg = STG_STOP;
                d.op  = OP_STOP;
            end
        end

        if (q.run && phy_done) begin
            if (phy_arb || phy_tmo) begin
                if (phy_arb) sts_set[S_ARB] = 1'b1;
                else         sts_set[S_TMO] = 1'b1;
                d.cmd   = '0;
                d.run   = 1'b0;
                d.owned = 1'b0;
            end else begin
                case (q.stg)
                    STG_START: begin
                        d.owned      = 1'b1;
                        d.cmd[C_STA] = 1'b0;
                        d.run        = 1'b0;
                    end
                    STG_STOP: begin
                        d.owned        = 1'b0;
                        d.cmd[C_STO]   = 1'b0;
                        d.run          = 1'b0;
                        sts_set[S_STP] = 1'b1;
                    end
                    STG_TX: begin
                        if (q.idx < ACK_SLOT) begin
                            d.idx = q.idx + 1'b1;
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.opv = 1'b1;
                            d.op  = OP_BIT;
                            if (q.idx == LAST_DATA) begin
                                d.wbit = 1'b1;
                                d.chk  = 1'b0;
                            end else begin
                                d.wbit = q.sh[BYTE_W-2];
                                d.chk  = 1'b1;
                            end
                        end else begin
                            if (phy_rbit) sts_set[S_NAK] = 1'b1;
                            else          sts_set[S_ACK] = 1'b1;
                            d.cmd[C_TX] = 1'b0;
                            d.run       = 1'b0;
                        end
                    end
                    default: begin
                        if (q.idx < ACK_SLOT) begin
                            d.idx  = q.idx + 1'b1;
                            d.sh   = {q.sh[BYTE_W-2:0], phy_rbit};
                            d.opv  = 1'b1;
                            d.op   = OP_BIT;
                            d.chk  = 1'b0;
                            d.wbit = (q.idx == LAST_DATA) ? q.cmd[C_LAST] : 1'b1;
                        end else begin
                            d.rx           = q.sh;
                            sts_set[S_RXD] = 1'b1;
                            d.cmd[C_RX]    = 1'b0;
                            d.cmd[C_LAST]  = 1'b0;
                            d.run          = 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.stg  <= STG_START;
            q.op   <= OP_START;
        end else begin
            q <= d;
        end
    end

    i2c_mbe_bitphy #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .op_valid (q.opv),
        .op_in    (q.op),
        .wbit_in  (q.wbit),
        .chk_in   (q.chk),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .done     (phy_done),
        .rbit     (phy_rbit),
        .arb      (phy_arb),
        .tmo      (phy_tmo),
        .scl_o    (scl_o),
        .sda_o    (sda_o)
    );

    i2c_mbe_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (sts_set),
        .clr_wr   (sts_clr_wr),
        .clr_data (sts_clr_data),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .sts      (sts_o),
        .irq      (irq)
    );

    assign buf_rdata   = {q.rx, q.tx};
    assign bus_busy    = q.owned;
    assign engine_idle = idle_now;
endmodule

// File: rtl/i2c_mbe_chk.sv
module i2c_mbe_chk
    import i2c_mbe_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [STS_W-1:0] sts_o,
    input logic             bus_busy,
    input logic             engine_idle,
    input logic             scl_o,
    input logic             sda_o
);
    // R2: ownership begins right after a START has pulled both lines low
    a_r2_start_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> (!scl_o && !sda_o));

    // R4: a normal stop leaves the bus free and released
    a_r4_stop_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[S_STP]) |-> (!bus_busy && scl_o && sda_o));

    // R6: arbitration loss flushes the queue and gives up the bus
    a_r6_arb_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[S_ARB]) |-> (engine_idle && !bus_busy && scl_o && sda_o));

    // R7: timeout releases both lines
    a_r7_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[S_TMO]) |-> (engine_idle && !bus_busy && scl_o && sda_o));

    // R8: a free, idle engine never holds a line low
    a_r8_free_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_idle && !bus_busy) |-> (scl_o && sda_o));
endmodule

bind i2c_mbe i2c_mbe_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sts_o       (sts_o),
    .bus_busy    (bus_busy),
    .engine_idle (engine_idle),
    .scl_o       (scl_o),
    .sda_o       (sda_o)
);

// File: tb/test_i2c_mbe.sv
`timescale 1ns/1ps
module test_i2c_mbe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  div = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [5:0]  cmd_wdata = '0;
    logic        buf_wr = 1'b0;
    logic [7:0]  buf_wdata = '0;
    logic [15:0] buf_rdata;
    logic        sts_clr_wr = 1'b0;
    logic [6:0]  sts_clr_data = '0;
    logic        en_wr = 1'b0;
    logic [6:0]  en_wdata = '0;
    logic [6:0]  sts_o;
    logic        irq, bus_busy, engine_idle, scl_o, sda_o, scl_i, sda_i;

    // target model
    logic        tb_scl = 1'b1;
    logic [8:0]  pat = 9'h1FF;
    logic [3:0]  cnt = '0;
    logic        cnt_clr = 1'b0;
    logic        scl_prev = 1'b1;
    logic [7:0]  mbyte = '0;
    logic        m9 = 1'b1;
    logic        tb_sda;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic over = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        div  <= div + 2'd1;
        tick <= (div == 2'd3);
    end

    assign tb_sda = (cnt >= 4'd1 && cnt <= 4'd9) ? pat[9 - cnt] : 1'b1;
    assign scl_i  = scl_o & tb_scl;
    assign sda_i  = sda_o & tb_sda;

    always @(posedge clk) begin
        scl_prev <= scl_i;
        if (cnt_clr) cnt <= '0;
        else if (scl_i && !scl_prev) begin
            if (cnt < 4'd8)  mbyte <= {mbyte[6:0], sda_o};
            if (cnt == 4'd8) m9 <= sda_o;
            if (cnt != 4'hF) cnt <= cnt + 4'd1;
        end
    end

    i2c_mbe i_i2c_mbe (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .sts_o(sts_o), .irq(irq), .bus_busy(bus_busy), .engine_idle(engine_idle),
        .scl_o(scl_o), .sda_o(sda_o), .scl_i(scl_i), .sda_i(sda_i)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !over) begin
            over = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            report();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] w, input logic clr);
        @(negedge clk);
        cmd_wdata = w; cmd_wr = 1'b1; cnt_clr = clr;
        @(negedge clk);
        cmd_wr = 1'b0; cnt_clr = 1'b0;
    endtask

    task automatic set_buf(input logic [7:0] v);
        @(negedge clk);
        buf_wdata = v; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic clr_sts(input logic [6:0] m);
        @(negedge clk);
        sts_clr_data = m; sts_clr_wr = 1'b1;
        @(negedge clk);
        sts_clr_wr = 1'b0;
    endtask

    task automatic set_en(input logic [6:0] m);
        @(negedge clk);
        en_wdata = m; en_wr = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        @(negedge clk);
        while (!engine_idle && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " idle"}, 32'(engine_idle), 32'd1);
    endtask

    task automatic run(input logic [5:0] w, input string tag);
        issue(w, 1'b1);
        wait_idle(tag);
    endtask

    initial begin
        logic [7:0] vals [8];
        vals = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h3C, 8'hC3};

        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 sts", 32'(sts_o), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 busy", 32'(bus_busy), 32'h0);
        chk("R1 idle", 32'(engine_idle), 32'h1);
        chk("R1 lines", 32'({scl_o, sda_o}), 32'h3);

        // R2 START + address, ACKed
        set_buf(8'hA6); pat = 9'h1FE;
        run(6'h03, "R2 addr");
        chk("R2 addr byte", 32'(mbyte), 32'hA6);
        chk("R2 ack sts", 32'(sts_o), 32'h01);
        chk("R2 busy", 32'(bus_busy), 32'h1);

        // R2 transmit sweep MSB first
        for (int i = 0; i < 8; i++) begin
            clr_sts(7'h7F);
            set_buf(vals[i]); pat = 9'h1FE;
            run(6'h02, "R2 tx");
            chk("R2 tx byte", 32'(mbyte), 32'(vals[i]));
            chk("R2 tx ack", 32'(sts_o), 32'h01);
        end

        // R9 writes while busy are ignored; R2 NACK
        clr_sts(7'h7F);
        set_buf(8'h3C); pat = 9'h1FF;
        issue(6'h02, 1'b1);
        repeat (20) @(negedge clk);
        issue(6'h20, 1'b0);
        set_buf(8'h99);
        wait_idle("R9");
        chk("R2 nack sts", 32'(sts_o), 32'h02);
        chk("R9 stop ignored busy", 32'(bus_busy), 32'h1);
        chk("R9 buf ignored", 32'(buf_rdata[7:0]), 32'h3C);
        chk("R9 tx byte", 32'(mbyte), 32'h3C);

        // R3 receive sweep with ACK
        for (int i = 0; i < 8; i++) begin
            clr_sts(7'h7F);
            pat = {vals[i], 1'b1};
            run(6'h08, "R3 rx");
            chk("R3 rx byte", 32'(buf_rdata[15:8]), 32'(vals[i]));
            chk("R3 rx sts", 32'(sts_o), 32'h04);
            chk("R3 master ack", 32'(m9), 32'h0);
        end
        // R3 receive-last NACK
        clr_sts(7'h7F);
        pat = {8'h81, 1'b1};
        run(6'h18, "R3 last");
        chk("R3 last byte", 32'(buf_rdata[15:8]), 32'h81);
        chk("R3 master nack", 32'(m9), 32'h1);

        // R4 STOP only
        clr_sts(7'h7F);
        run(6'h20, "R4");
        chk("R4 sts", 32'(sts_o), 32'h10);
        chk("R4 busy", 32'(bus_busy), 32'h0);
        chk("R4 lines", 32'({scl_o, sda_o}), 32'h3);

        // R5 combined START|TX|STOP
        clr_sts(7'h7F);
        set_buf(8'h5B); pat = 9'h1FE;
        run(6'h23, "R5 tx");
        chk("R5 tx byte", 32'(mbyte), 32'h5B);
        chk("R5 tx sts", 32'(sts_o), 32'h11);
        chk("R5 busy", 32'(bus_busy), 32'h0);

        // R11 interrupt masking, sweep each enable bit
        for (int i = 0; i < 7; i++) begin
            set_en(7'(1 << i));
            @(negedge clk);
            chk("R11 irq", 32'(irq), 32'((7'h11 >> i) & 7'h1));
        end
        set_en(7'h00);
        @(negedge clk);
        chk("R11 irq off", 32'(irq), 32'h0);

        // R10 write-1-to-clear
        clr_sts(7'h01);
        chk("R10 clear one", 32'(sts_o), 32'h10);
        clr_sts(7'h00);
        chk("R10 clear none", 32'(sts_o), 32'h10);
        clr_sts(7'h10);
        chk("R10 clear rest", 32'(sts_o), 32'h00);

        // R5 combined START|RX|LAST|STOP
        pat = {8'h6E, 1'b1};
        run(6'h39, "R5 rx");
        chk("R5 rx byte", 32'(buf_rdata[15:8]), 32'h6E);
        chk("R5 rx sts", 32'(sts_o), 32'h14);
        chk("R5 rx nack", 32'(m9), 32'h1);

        // R6 arbitration loss with STOP queued
        clr_sts(7'h7F);
        set_buf(8'hFF); pat = 9'h1BF;
        run(6'h23, "R6");
        chk("R6 sts", 32'(sts_o), 32'h08);
        chk("R6 busy", 32'(bus_busy), 32'h0);
        chk("R6 lines", 32'({scl_o, sda_o}), 32'h3);

        // R7 SCL held low
        clr_sts(7'h7F);
        tb_scl = 1'b0; pat = 9'h1FE;
        run(6'h03, "R7");
        chk("R7 sts", 32'(sts_o), 32'h40);
        chk("R7 busy", 32'(bus_busy), 32'h0);
        chk("R7 lines", 32'({scl_o, sda_o}), 32'h3);
        tb_scl = 1'b1;

        // R8 malformed commands
        begin
            logic [5:0] badc [4];
            badc = '{6'h02, 6'h0B, 6'h10, 6'h20};
            for (int i = 0; i < 4; i++) begin
                clr_sts(7'h7F);
                run(badc[i], "R8");
                chk("R8 abnormal", 32'(sts_o), 32'h20);
                chk("R8 lines", 32'({scl_o, sda_o, bus_busy}), 32'h6);
                chk("R8 no clocks", 32'(cnt), 32'h0);
            end
        end

        over = 1'b1;
        report();
    end
endmodule